// File: doc/BRIEF.md
# Self-Test Session and Unload Sequencer

This block sequences one built-in self-test session for a data path whose module groups need different test lengths. A start pulse while idle raises a test-mode flag, clears the pattern and period counters, and enables every group's pattern generators and signature register together. Groups of the short kind stop after one base period of patterns. Groups of the long kind keep running for four base periods. Every group that has been started runs to its full length unless the session is halted.

Once the longest group has finished, a phase flag moves the session from pattern application to unloading. A shift enable is held for a counted number of cycles: the number of signature registers times the word width. During that time the tail bit of the chained signature registers is returned on a registered serial output, together with a valid strobe. A fail flag from a group whose enable is high halts the session at once and skips the unload. The session then ends with a held done flag and an overall pass result.

Top module: `bist_session_seq`

## Requirements
- R1: After reset, test_mode, every bit of grp_en, shift_en, ser_valid, ser_data, done and pass are all 0.
- R2: A start pulse sampled while test_mode is 0 makes test_mode 1 and sets every bit of grp_en to 1 in the next cycle, and clears done and pass in that same cycle.
- R3: A group whose bit in LONG_MASK is 0 keeps its grp_en bit high for exactly 2^PAT_W cycles (64 by default).
- R4: A group whose bit in LONG_MASK is 1 keeps its grp_en bit high for exactly 2^(PAT_W+PER_W) cycles (256 by default).
- R5: shift_en rises in the cycle after the last pattern cycle of the longest group. It then stays high for exactly N_SIG*WORD_W cycles (24 by default), and grp_en is all 0 while it is high.
- R6: ser_valid is shift_en delayed by one cycle. When ser_valid is 1, ser_data equals the value sig_chain_bit had one cycle earlier.
- R7: done rises and test_mode falls in the cycle after the last shift_en cycle, with pass 1 if no fail was accepted.
- R8: A grp_fail bit that is 1 while the matching grp_en bit is 1 halts the session in the next cycle. In that cycle grp_en is all 0, test_mode is 0, done is 1 and pass is 0, and shift_en never rises.
- R9: A grp_fail bit whose grp_en bit is 0 has no effect. This covers a group that has already finished and the whole unload phase.
- R10: start is ignored while test_mode is 1, and the session ends at its normal cycle.
- R11: done and pass keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Session start request |
| grp_fail | input | N_GRP | Comparator mismatch flag per group |
| sig_chain_bit | input | 1 | Tail bit of the chained signature registers |
| test_mode | output | 1 | Session in progress |
| grp_en | output | N_GRP | Pattern generator and signature enable per group |
| shift_en | output | 1 | Signature chain shift enable |
| ser_data | output | 1 | Registered serial signature bit |
| ser_valid | output | 1 | ser_data carries a signature bit |
| done | output | 1 | Session finished, held |
| pass | output | 1 | Session finished without a fail, held |

## Verification
The delicate overlap is a short group's last pattern cycle meeting a fail flag, and the longest group's last pattern cycle meeting a fail or the handoff to unloading. The bench injects a fail exactly on cycle 63 and then on cycle 64 for a short group, and on cycles 255 and 256 for the long group. The halt is judged by the cycle in which done rises and by the pass value. A fail on the last enabled cycle must end the session one cycle later with pass low. A fail one cycle later must leave the session ending at its normal cycle with pass high.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;
  function automatic int unsigned pow2(input int unsigned w);
    return 32'd1 << w;
  endfunction
endpackage

// File: rtl/bist_pattern_timer.sv
module bist_pattern_timer #(
  parameter int PAT_W = 6,
  parameter int PER_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  output logic [PER_W-1:0] per_cnt,
  output logic             base_last,
  output logic             period_last
);
  logic [PAT_W-1:0] pat_cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pat_cnt <= '0;
      per_cnt <= '0;
    end else if (run) begin
      pat_cnt <= pat_cnt + 1'b1;
      if (&pat_cnt) per_cnt <= per_cnt + 1'b1;
    end
  end

  assign base_last   = &pat_cnt;
  assign period_last = (&pat_cnt) && (&per_cnt);
endmodule

// File: rtl/bist_group_gate.sv
module bist_group_gate #(
  parameter int                N_GRP     = 3,
  parameter logic [N_GRP-1:0]  LONG_MASK = 3'b100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             kill,
  input  logic             short_end,
  input  logic             long_end,
  output logic [N_GRP-1:0] en
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic end_hit;
    if (LONG_MASK[g]) begin : g_long
      assign end_hit = long_end;
    end else begin : g_short
      assign end_hit = short_end;
    end

    always_ff @(posedge clk) begin
      if (rst)                 en[g] <= 1'b0;
      else if (launch)         en[g] <= 1'b1;
      else if (kill || end_hit) en[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/bist_unload_counter.sv
module bist_unload_counter #(
  parameter int LEN = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic last
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  logic [CW-1:0] cnt;

  assign last = run && (cnt == CW'(LEN - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (last)   cnt <= '0;
    else if (run)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bist_session_seq.sv
module bist_session_seq
  import bist_seq_pkg::*;
#(
  parameter int               N_GRP     = 3,
  parameter logic [N_GRP-1:0] LONG_MASK = 3'b100,
  parameter int               PAT_W     = 6,
  parameter int               PER_W     = 2,
  parameter int               N_SIG     = 3,
  parameter int               WORD_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [N_GRP-1:0] grp_fail,
  input  logic             sig_chain_bit,
  output logic             test_mode,
  output logic [N_GRP-1:0] grp_en,
  output logic             shift_en,
  output logic             ser_data,
  output logic             ser_valid,
  output logic             done,
  output logic             pass
);
  localparam int  UNLOAD_LEN = N_SIG * WORD_W;
  localparam bit  HAS_LONG   = |LONG_MASK;
  localparam int  SHORT_LEN  = pow2(PAT_W);

  logic             unload_phase;
  logic [PER_W-1:0] per_cnt;
  logic             base_last, period_last;
  logic             short_end, long_end, test_end;
  logic             accept, applying, halt, unl_last;

  assign accept    = start && !test_mode;
  assign applying  = test_mode && !unload_phase;
  assign halt      = applying && |(grp_fail & grp_en);
  assign short_end = applying && base_last && (per_cnt == '0);
  assign long_end  = applying && period_last;
  assign test_end  = HAS_LONG ? long_end : short_end;

  bist_pattern_timer #(.PAT_W(PAT_W), .PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .clr(accept), .run(applying && !halt),
    .per_cnt(per_cnt), .base_last(base_last), .period_last(period_last)
  );

  bist_group_gate #(.N_GRP(N_GRP), .LONG_MASK(LONG_MASK)) u_gate (
    .clk(clk), .rst(rst), .launch(accept), .kill(halt),
    .short_end(short_end), .long_end(long_end), .en(grp_en)
  );

  bist_unload_counter #(.LEN(UNLOAD_LEN)) u_unload (
    .clk(clk), .rst(rst), .clr(accept), .run(shift_en), .last(unl_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      test_mode    <= 1'b0;
      unload_phase <= 1'b0;
      shift_en     <= 1'b0;
      done         <= 1'b0;
      pass         <= 1'b0;
    end else if (accept) begin
      test_mode    <= 1'b1;
      unload_phase <= 1'b0;
      shift_en     <= 1'b0;
      done         <= 1'b0;
      pass         <= 1'b0;
    end else if (halt) begin
      test_mode    <= 1'b0;
      done         <= 1'b1;
      pass         <= 1'b0;
    end else if (test_end) begin
      unload_phase <= 1'b1;
      shift_en     <= 1'b1;
    end else if (unl_last) begin
      shift_en     <= 1'b0;
      unload_phase <= 1'b0;
      test_mode    <= 1'b0;
      done         <= 1'b1;
      pass         <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_valid <= 1'b0;
      ser_data  <= 1'b0;
    end else begin
      ser_valid <= shift_en;
      ser_data  <= shift_en ? sig_chain_bit : 1'b0;
    end
  end

  if (SHORT_LEN < 2) begin : g_bad_param
    initial $error("PAT_W too small");
  end
endmodule

// File: rtl/bist_session_chk.sv
module bist_session_chk #(
  parameter int               N_GRP     = 3,
  parameter logic [N_GRP-1:0] LONG_MASK = 3'b100,
  parameter int               PAT_W     = 6,
  parameter int               PER_W     = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [N_GRP-1:0] grp_fail,
  input logic             test_mode,
  input logic [N_GRP-1:0] grp_en,
  input logic             shift_en,
  input logic             ser_valid,
  input logic             done,
  input logic             pass
);
  localparam int SHORT_LEN = 1 << PAT_W;
  localparam int LONG_LEN  = 1 << (PAT_W + PER_W);
  localparam int CW        = PAT_W + PER_W + 1;

  logic [CW-1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst || !test_mode) cyc <= '0;
    else if (!(&cyc))      cyc <= cyc + 1'b1;
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_len
    if (LONG_MASK[g]) begin : g_l
      assert_long_len_R4: assert property (@(posedge clk) disable iff (rst)
        grp_en[g] |-> (cyc < CW'(LONG_LEN)));
    end else begin : g_s
      assert_short_len_R3: assert property (@(posedge clk) disable iff (rst)
        grp_en[g] |-> (cyc < CW'(SHORT_LEN)));
    end
    assert_en_launch_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(grp_en[g]) |-> ($past(start) && !$past(test_mode)));
  end

  assert_shift_excl_R5: assert property (@(posedge clk) disable iff (rst)
    shift_en |-> (test_mode && grp_en == '0));

  assert_valid_lag_R6: assert property (@(posedge clk) disable iff (rst)
    $past(shift_en) |-> ser_valid);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !test_mode);

  assert_pass_after_unload_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && pass) |-> $past(shift_en));

  assert_halt_R8: assert property (@(posedge clk) disable iff (rst)
    (test_mode && !shift_en && |(grp_fail & grp_en)) |=> (done && !pass && !shift_en));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(pass)));
endmodule

bind bist_session_seq bist_session_chk #(
  .N_GRP(N_GRP), .LONG_MASK(LONG_MASK), .PAT_W(PAT_W), .PER_W(PER_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .grp_fail(grp_fail),
  .test_mode(test_mode), .grp_en(grp_en), .shift_en(shift_en),
  .ser_valid(ser_valid), .done(done), .pass(pass)
);

// File: tb/sim_bist_session_seq.sv
module sim_bist_session_seq;
  localparam int N_GRP = 3;
  localparam int UL    = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [N_GRP-1:0] grp_fail = '0;
  logic sig_chain_bit = 1'b0;
  logic test_mode, shift_en, ser_data, ser_valid, done, pass;
  logic [N_GRP-1:0] grp_en;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bist_session_seq u0 (
    .clk(clk), .rst(rst), .start(start), .grp_fail(grp_fail),
    .sig_chain_bit(sig_chain_bit), .test_mode(test_mode), .grp_en(grp_en),
    .shift_en(shift_en), .ser_data(ser_data), .ser_valid(ser_valid),
    .done(done), .pass(pass)
  );

  // columns: fail group (-1 none), fail cycle, extra start cycle, expected done cycle, expected pass
  localparam int NV = 8;
  localparam int TV [NV][5] = '{
    '{-1,  -1,  -1, 280, 1},   // R7 clean session
    '{ 0,  10,  -1,  11, 0},   // R8 early halt
    '{ 0,  63,  -1,  64, 0},   // R8 fail on last short cycle
    '{ 0,  64,  -1, 280, 1},   // R9 fail after short group finished
    '{ 2, 255,  -1, 256, 0},   // R8 fail on last long cycle
    '{ 2, 256,  -1, 280, 1},   // R9 fail in unload
    '{-1,  -1, 100, 280, 1},   // R10 start while busy
    '{ 1, 270,  -1, 280, 1}    // R9 fail in unload, other group
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_row(input int fg, input int fc, input int sc,
                         input int exp_done, input int exp_pass);
    int c = 0;
    int done_c = -1;
    int en_cnt [N_GRP];
    int sh_cnt = 0;
    int vl_cnt = 0;
    int ser_bad = 0;
    logic last_bit = 1'b0;
    for (int g = 0; g < N_GRP; g++) en_cnt[g] = 0;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    while (c < 2000) begin
      @(negedge clk);
      if (c == 0) begin
        check(test_mode == 1'b1, "R2 test_mode", int'(test_mode), 1);
        check(grp_en == '1, "R2 grp_en", int'(grp_en), 7);
        check(done == 1'b0 && pass == 1'b0, "R2 done/pass cleared", int'({done, pass}), 0);
      end
      for (int g = 0; g < N_GRP; g++) if (grp_en[g]) en_cnt[g]++;
      if (shift_en) sh_cnt++;
      if (ser_valid) begin
        vl_cnt++;
        if (ser_data !== last_bit) ser_bad++;
      end
      if (done) begin
        done_c = c;
        break;
      end
      last_bit = c[0] ^ c[2] ^ c[4];
      sig_chain_bit = last_bit;
      start = (c == sc);
      grp_fail = '0;
      if (fg >= 0 && c == fc) grp_fail[fg] = 1'b1;
      @(posedge clk);
      c++;
    end
    start = 1'b0;
    grp_fail = '0;
    check(done_c == exp_done, "R7/R8 done cycle", done_c, exp_done);
    check(int'(pass) == exp_pass, "R7/R8 pass", int'(pass), exp_pass);
    if (exp_pass == 1) begin
      check(en_cnt[0] == 64, "R3 group0 enable length", en_cnt[0], 64);
      check(en_cnt[1] == 64, "R3 group1 enable length", en_cnt[1], 64);
      check(en_cnt[2] == 256, "R4 group2 enable length", en_cnt[2], 256);
      check(sh_cnt == UL, "R5 shift length", sh_cnt, UL);
      check(vl_cnt == UL, "R6 valid count", vl_cnt, UL);
      check(ser_bad == 0, "R6 serial data", ser_bad, 0);
    end else begin
      check(sh_cnt == 0, "R8 no unload after halt", sh_cnt, 0);
      check(test_mode == 1'b0 && grp_en == '0, "R8 halted outputs",
            int'({test_mode, grp_en}), 0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({test_mode, grp_en, shift_en, ser_valid, ser_data, done, pass} == '0,
          "R1 reset state", int'({test_mode, grp_en, shift_en, ser_valid, ser_data, done, pass}), 0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++)
      run_row(TV[i][0], TV[i][1], TV[i][2], TV[i][3], TV[i][4]);
    // R11: done and pass hold while idle, fail inputs ignored
    grp_fail = '1;
    repeat (5) @(negedge clk);
    check(done == 1'b1 && pass == 1'b1, "R11 done/pass held", int'({done, pass}), 3);
    check(test_mode == 1'b0 && grp_en == '0, "R9 fail while idle ignored",
          int'({test_mode, grp_en}), 0);
    grp_fail = '0;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule